// File: doc/BRIEF.md
# Key auto-repeat generator

This block turns a single held key into a train of key events. The moment a held key is first seen, it emits one event pulse, and it clears a shared tick counter. It then counts ticks of a slow timebase that is delivered as a one-cycle enable on the system clock. If the key is still down after a fixed hold delay (2000 ticks by default, which is half a second at 4 kHz), the block emits a repeat event. After that it emits one more event each time a user-selected repeat interval elapses. Each event pulse tells the downstream transmit logic to mark the held key's code as pending again, so the same code goes out once more.

The repeat interval comes from a 4-bit rate setting. The period is (setting + 1) times a base step of 100 ticks, which spans 25 ms to 400 ms at 4 kHz. The setting is compared live against the running count, so a change takes effect on the next tick without waiting for the current interval to finish. Releasing the key stops all events in the next cycle and clears the counter. A new press therefore always starts from a fresh hold delay.

Top module: `key_autorepeat`

## Requirements
- R1: While `rst_n` is low, `key_event` is 0 in every cycle after the first clock edge, even when `key_held` is 1.
- R2: On the first clock edge at which `key_held` is sampled 1 after being idle (released or out of reset), `key_event` is 1 for the following cycle, regardless of `tick`.
- R3: The first repeat event follows the clock edge that samples the HOLD_TICKS-th `tick` after the press edge, counting only ticks sampled while the key stays held. No event is produced between the press event and that edge.
- R4: Once repeating, an event follows every clock edge at which the number of ticks sampled since the previous event reaches P = (rate_sel + 1) * BASE_TICKS, with rate_sel read as an unsigned number.
- R5: A clock edge that samples `key_held` at 0 produces no event in the following cycle and clears the tick count. The next press restarts at R2 and then needs the full hold delay again.
- R6: The repeat period is compared against the current `rate_sel`. If the ticks counted since the last event already reach the newly selected P, the next sampled tick produces an event.
- R7: `tick` pulses have no effect while `key_held` is 0, and no event is produced in a cycle whose preceding edge sampled neither a press nor a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle enable marking one timebase tick |
| key_held | input | 1 | High while a key is held down |
| rate_sel | input | RATE_W | Repeat interval setting, period = (rate_sel + 1) * BASE_TICKS ticks |
| key_event | output | 1 | One-cycle pulse per key event (initial press or repeat) |

## Verification
The hardest situation to reach from the ports is a rate change in the middle of an interval, where the count already exceeds the newly selected period. Reaching it needs a key held through the whole hold delay and part of a long interval, followed by a drop to the shortest rate. The bench scales the hold delay and base step down to a few ticks and sweeps every rate setting. It then runs a directed hold in which the rate falls from a long period to the shortest one after several ticks have been counted. Presses, releases and ticks that land on the same clock edge, and releases in the middle of the hold delay, are also driven with a bench-side pseudo-random tick pattern.

// File: rtl/ar_pkg.sv
// Package: shared types and helpers for the key auto-repeat generator.
// Assumes: nothing beyond IEEE 1800-2017 elaboration-time functions.
package ar_pkg;

    // Controller phases: waiting for a press, timing the hold delay, repeating.
    typedef enum logic [1:0] {
        AR_IDLE   = 2'd0,
        AR_HOLD   = 2'd1,
        AR_REPEAT = 2'd2
    } ar_state_e;

    // Larger of two integers, used to size the shared counter.
    function automatic int ar_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ar_tick_counter.sv
// Module: ar_tick_counter
// Counts timebase ticks for both the hold delay and the repeat interval.
// Assumes: clr has priority over inc; the count saturates at all-ones so it
// never wraps back into a small value that would fake an elapsed period.
module ar_tick_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;

    // Clear, advance on tick, or hold the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (inc && (count_q != CNT_MAX)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    // R5: a clear request always empties the count on the next cycle.
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0));

    // R4: an advance request moves the count up by exactly one.
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && (count_q != CNT_MAX)) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/ar_rate_decode.sv
// Module: ar_rate_decode
// Converts the repeat-rate setting into a period length in ticks:
// period = (rate + 1) * BASE_TICKS.
// Assumes: CNT_W is wide enough for (2**RATE_W) * BASE_TICKS.
module ar_rate_decode #(
    parameter int RATE_W     = 4,
    parameter int BASE_TICKS = 100,
    parameter int CNT_W      = 12
) (
    input  logic [RATE_W-1:0] rate,
    output logic [CNT_W-1:0]  period
);
    localparam bit BASE_POW2  = ((BASE_TICKS & (BASE_TICKS - 1)) == 0);
    localparam int BASE_SHIFT = $clog2(BASE_TICKS);

    logic [CNT_W:0] steps;

    // Number of base steps in one period.
    always_comb steps = (CNT_W+1)'(rate) + 1'b1;

    generate
        if (BASE_POW2) begin : g_shift
            // A power-of-two base step needs only a shift.
            always_comb period = CNT_W'(steps << BASE_SHIFT);
        end else begin : g_mult
            // Any other base step uses a constant multiply.
            always_comb period = CNT_W'(steps * (CNT_W+1)'(BASE_TICKS));
        end
    endgenerate

endmodule

// File: rtl/ar_ctrl.sv
// Module: ar_ctrl
// Phase controller: emits the press event, times the hold delay, then
// emits one repeat event per elapsed period while the key stays down.
// Assumes: tick and key_held are synchronous to clk; period >= 1.
module ar_ctrl
    import ar_pkg::*;
#(
    parameter int HOLD_TICKS = 2000,
    parameter int CNT_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             key_held,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             key_event
);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

    ar_state_e state_q, state_d;
    logic      fire;
    logic      event_q;
    logic [CNT_W-1:0] period_last;

    // Last count value of the current repeat period.
    always_comb period_last = period - 1'b1;

    // Next phase, counter control and event decision.
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        fire    = 1'b0;
        if (!key_held) begin
            state_d = AR_IDLE;
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                AR_IDLE: begin
                    state_d = AR_HOLD;
                    cnt_clr = 1'b1;
                    fire    = 1'b1;
                end
                AR_HOLD: begin
                    if (tick) begin
                        if (cnt >= HOLD_LAST) begin
                            state_d = AR_REPEAT;
                            cnt_clr = 1'b1;
                            fire    = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                AR_REPEAT: begin
                    if (tick) begin
                        if (cnt >= period_last) begin
                            cnt_clr = 1'b1;
                            fire    = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = AR_IDLE;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // Phase register and registered event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AR_IDLE;
            event_q <= 1'b0;
        end else begin
            state_q <= state_d;
            event_q <= fire;
        end
    end

    assign key_event = event_q;

    // R1: reset keeps the event output low.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !key_event);

    // R2: a press from idle always produces an event next cycle.
    assert_press_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == AR_IDLE && key_held) |=> key_event);

    // R3: no event while the hold delay is still running.
    assert_hold_no_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == AR_HOLD && key_held && cnt < HOLD_LAST) |=> !key_event);

    // R5: a sampled release silences the output next cycle.
    assert_release_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !key_held |=> !key_event);

    // R7: after the press, events need a tick.
    assert_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != AR_IDLE && !tick) |=> !key_event);

endmodule

// File: rtl/key_autorepeat.sv
// Module: key_autorepeat (top)
// Key auto-repeat generator: one event on press, a repeat after a fixed
// hold delay, then one event per user-selected interval until release.
// Assumes: tick is a one-cycle enable from a slow timebase (4 kHz default),
// all inputs synchronous to clk, reset synchronous and active low.
module key_autorepeat
    import ar_pkg::*;
#(
    parameter int HOLD_TICKS = 2000,
    parameter int BASE_TICKS = 100,
    parameter int RATE_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              key_held,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              key_event
);
    localparam int RATE_STEPS = 1 << RATE_W;
    localparam int LONGEST    = ar_max(HOLD_TICKS, RATE_STEPS * BASE_TICKS);
    localparam int CNT_W      = $clog2(LONGEST + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;
    logic             cnt_clr;
    logic             cnt_inc;

    ar_rate_decode #(
        .RATE_W     (RATE_W),
        .BASE_TICKS (BASE_TICKS),
        .CNT_W      (CNT_W)
    ) u_rate (
        .rate   (rate_sel),
        .period (period)
    );

    ar_tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    ar_ctrl #(
        .HOLD_TICKS (HOLD_TICKS),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .key_held  (key_held),
        .cnt       (cnt),
        .period    (period),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .key_event (key_event)
    );

endmodule

// File: tb/tb_key_autorepeat.sv
// Bench: sweeps every rate setting on a scaled-down configuration and
// predicts each cycle's event from the tick arithmetic of the requirements.
module tb_key_autorepeat;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD_T     = 8;
    localparam int BASE_T     = 3;
    localparam int RW         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          key_held = 1'b0;
    logic [RW-1:0] rate_sel = '0;
    logic          key_event;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    // Reference model: 0 idle, 1 hold, 2 repeat; ticks since last event.
    int  m_phase = 0;
    int  m_k     = 0;
    bit  rate_moved = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_autorepeat #(
        .HOLD_TICKS (HOLD_T),
        .BASE_TICKS (BASE_T),
        .RATE_W     (RW)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .key_held  (key_held),
        .rate_sel  (rate_sel),
        .key_event (key_event)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: key_event=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, predict the event, check it after the edge.
    task automatic step(input logic h, input logic t);
        logic  exp;
        string req;
        int    per;
        per = (int'(rate_sel) + 1) * BASE_T;
        key_held = h;
        tick     = t;
        exp      = 1'b0;
        if (!h) begin
            req = (m_phase == 0 && t) ? "R7" : "R5";
            m_phase = 0;
            m_k = 0;
        end else if (m_phase == 0) begin
            req = "R2";
            m_phase = 1;
            m_k = 0;
            exp = 1'b1;
        end else if (!t) begin
            req = (m_phase == 1) ? "R3" : "R7";
        end else if (m_phase == 1) begin
            req = "R3";
            if (m_k + 1 == HOLD_T) begin
                m_phase = 2;
                m_k = 0;
                exp = 1'b1;
            end else begin
                m_k++;
            end
        end else begin
            req = rate_moved ? "R6" : "R4";
            if (m_k + 1 >= per) begin
                m_k = 0;
                exp = 1'b1;
            end else begin
                m_k++;
            end
        end
        @(posedge clk);
        #1;
        check(key_event, exp, req);
    endtask

    function automatic logic next_rand_tick();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0] & lfsr[3];
    endfunction

    initial begin
        // R1: reset with the key held produces nothing.
        key_held = 1'b1;
        tick     = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #1;
            check(key_event, 1'b0, "R1");
        end
        rst_n = 1'b1;
        m_phase = 0;

        // R2/R3/R4: press straight out of reset, full sweep of rate settings.
        for (int r = 0; r < 16; r++) begin
            rate_sel = RW'(r);
            for (int c = 0; c < 3 * (HOLD_T + 3 * (r + 1) * BASE_T) + 2; c++)
                step(1'b1, (c % 3) == 1);
            step(1'b0, 1'b0);
            step(1'b0, 1'b1);
        end

        // R7: ticks while released do nothing.
        for (int c = 0; c < 20; c++) step(1'b0, 1'b1);

        // R2/R3: tick on the press edge and ticks every cycle.
        rate_sel = RW'(0);
        for (int c = 0; c < 40; c++) step(1'b1, 1'b1);
        step(1'b0, 1'b1);

        // R5: releases at every point of the hold delay, then re-press.
        for (int len = 0; len < HOLD_T + 3; len++) begin
            for (int c = 0; c < len; c++) step(1'b1, 1'b1);
            step(1'b0, 1'b1);
        end

        // R4/R5: pseudo-random tick pattern with occasional releases.
        for (int r = 0; r < 16; r += 5) begin
            rate_sel = RW'(r);
            for (int c = 0; c < 400; c++)
                step((c % 131) != 130, next_rand_tick());
        end
        step(1'b0, 1'b0);

        // R6: shorten the rate after part of a long interval.
        rate_sel = RW'(7);
        step(1'b1, 1'b0);
        for (int c = 0; c < HOLD_T; c++) step(1'b1, 1'b1);
        for (int c = 0; c < 5; c++) step(1'b1, 1'b1);
        rate_sel = RW'(0);
        rate_moved = 1'b1;
        step(1'b1, 1'b1);
        for (int c = 0; c < 12; c++) step(1'b1, (c % 2) == 0);
        // R6: lengthen it again mid-interval.
        rate_sel = RW'(15);
        for (int c = 0; c < 60; c++) step(1'b1, 1'b1);
        rate_moved = 1'b0;
        step(1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule